// File: doc/BRIEF.md
# CCD Horizontal Line Timing Generator

This block produces the timing of one horizontal line for an interline-transfer CCD. It runs on a master clock at twice the pixel rate and counts pixels from 0 to 2639. Each pixel period lasts two master clocks. From that count it drives the line sync pulse, the two complementary horizontal shift clocks and the reset gate pulse. It also drives four vertical transfer phases, which step only inside the blanking interval at the start of the line. Four region flags mark the front optical-black, prescan dummy, image and rear optical-black pixels of the readout.

A frame-level sequencer outside this block supplies two inputs. One selects the accumulation mode. In field mode the vertical steps are spaced 28 pixels apart; in frame mode they are spaced 56 apart. The other input says whether the line carries a vertical transfer at all. Both inputs are captured once per line, when the count returns to 0.

Top module: `ccd_line_timing`

## Requirements
- R1: The line lasts 2640 pixel periods of two master clocks each. The sync output is high for exactly the two master clocks of pixel 0 and low for every other pixel.
- R2: The mode and transfer-enable inputs take effect only at the start of a line (pixel 0, first half). A change at any other time has no effect until the next line starts.
- R3: From pixel 260 to pixel 2639, the first horizontal clock is high in the first half of each pixel and low in the second half. The second horizontal clock is always its complement.
- R4: For pixels 0 to 259 (blanking), the first horizontal clock is held low and the second is held high.
- R5: The reset gate output is high for one master clock, the first half of every pixel, and low otherwise.
- R6: The phase vector vphi[3:0] idles at 4'b0011. On a transfer line it rotates left by one bit (bit 3 moves to bit 0) at each edge pixel below 260. In field mode the edges are at 54+28*i for i=0..7. In frame mode they are at 54+56*i for i=0..3. From pixel 260 onward vphi is back at 4'b0011. On a line without transfer it stays at 4'b0011 for the whole line.
- R7: The region flags are region[0]=front optical black for pixels 260–261, region[1]=prescan for 262–285, region[2]=image for 286–2381 and region[3]=rear optical black for 2382–2435. All four flags are 0 for every other pixel.
- R8: The region flags change only in the master clock where the first horizontal clock rises. The vertical phases change only while both horizontal clocks are static.
- R9: While reset is asserted, the outputs are sync=0, first clock=0, second clock=1, reset gate=0, vphi=4'b0011 and region=0. After reset is released, the first master clock edge starts pixel 0 of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_mode | input | 1 | 0 = field spacing, 1 = frame spacing; captured at line start |
| xfer_line | input | 1 | 1 = this line carries a vertical transfer; captured at line start |
| hd | output | 1 | Line sync, high during pixel 0 |
| h1 | output | 1 | First horizontal shift clock |
| h2 | output | 1 | Second horizontal shift clock, complement of h1 |
| rg | output | 1 | Reset gate pulse |
| vphi | output | 4 | Vertical transfer phases |
| region | output | 4 | Pixel region flags (front OB, prescan, image, rear OB) |

## Verification
Some properties can be checked on every cycle, and the assertions cover them. These are: the horizontal clocks are always complementary, the reset gate is one clock wide, the sync pulse lasts two clocks, exactly two vertical phases are high, at most one region flag is set, region changes line up with the rising first clock, and phase steps happen only while the horizontal clocks are frozen. The exact pixel numbers of every edge and region boundary cannot be checked that way. Nor can the difference between field and frame spacing, or capture of the inputs only at line start. Only the bench shows these. It compares every master clock against a model across lines with directed and random mode choices, and it toggles the inputs mid-line.

// File: rtl/ccd_line_timing_pkg.sv
package ccd_line_timing_pkg;
  parameter int unsigned LINE_PIX   = 2640;
  parameter int unsigned SUB_TICKS  = 2;
  parameter int unsigned BLANK_END  = 260;
  parameter int unsigned EDGE_FIRST = 54;
  parameter int unsigned EDGE_STEP  = 28;
  parameter int unsigned EDGE_MAX   = 8;
  parameter int unsigned N_PHASE    = 4;
  parameter int unsigned OB_FRONT   = 2;
  parameter int unsigned PRESCAN    = 24;
  parameter int unsigned IMG_PIX    = 2096;
  parameter int unsigned OB_REAR    = 54;
  parameter int unsigned N_REGION   = 4;

  localparam int unsigned RG_FOB  = 0;
  localparam int unsigned RG_PRE  = 1;
  localparam int unsigned RG_IMG  = 2;
  localparam int unsigned RG_ROB  = 3;

  typedef enum logic {MODE_FIELD = 1'b0, MODE_FRAME = 1'b1} acc_mode_t;
endpackage

// File: rtl/ccd_line_counter.sv
module ccd_line_counter #(
  parameter int unsigned LINE_PIX  = 2640,
  parameter int unsigned SUB_TICKS = 2,
  localparam int unsigned PW = $clog2(LINE_PIX),
  localparam int unsigned SW = (SUB_TICKS > 1) ? $clog2(SUB_TICKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] sub_d,
  output logic [PW-1:0] pix_d,
  output logic          line_start
);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUB_TICKS - 1);
  localparam logic [PW-1:0] PIX_LAST = PW'(LINE_PIX - 1);

  logic [SW-1:0] sub_q;
  logic [PW-1:0] pix_q;
  logic          pix_adv;

  always_comb begin
    pix_adv = (sub_q == SUB_LAST);
    sub_d   = pix_adv ? '0 : sub_q + 1'b1;
    pix_d   = pix_q;
    if (pix_adv) pix_d = (pix_q == PIX_LAST) ? '0 : pix_q + 1'b1;
    line_start = pix_adv && (pix_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= SUB_LAST;
      pix_q <= PIX_LAST;
    end else begin
      sub_q <= sub_d;
      if (pix_adv) pix_q <= pix_d;
    end
  end
endmodule

// File: rtl/ccd_vphase_gen.sv
module ccd_vphase_gen #(
  parameter int unsigned PW         = 12,
  parameter int unsigned BLANK_END  = 260,
  parameter int unsigned EDGE_FIRST = 54,
  parameter int unsigned EDGE_STEP  = 28,
  parameter int unsigned EDGE_MAX   = 8,
  parameter int unsigned N_PHASE    = 4
) (
  input  logic [PW-1:0]      pix,
  input  logic               frame_sel,
  input  logic               xfer_en,
  output logic [N_PHASE-1:0] vphi_d
);
  localparam logic [N_PHASE-1:0] IDLE = N_PHASE'(2'b11);

  logic [EDGE_MAX-1:0] passed;
  logic                in_blank;

  assign in_blank = (pix < PW'(BLANK_END));

  for (genvar i = 0; i < EDGE_MAX; i++) begin : g_edge
    localparam int unsigned AT_FIELD = EDGE_FIRST + i * EDGE_STEP;
    localparam int unsigned AT_FRAME = EDGE_FIRST + i * 2 * EDGE_STEP;
    localparam bit OK_FIELD = (AT_FIELD < BLANK_END);
    localparam bit OK_FRAME = (AT_FRAME < BLANK_END);
    logic hit_field, hit_frame;
    assign hit_field = OK_FIELD && (pix >= PW'(AT_FIELD));
    assign hit_frame = OK_FRAME && (pix >= PW'(AT_FRAME));
    assign passed[i] = in_blank && (frame_sel ? hit_frame : hit_field);
  end

  always_comb begin
    vphi_d = IDLE;
    if (xfer_en) begin
      for (int k = 0; k < EDGE_MAX; k++) begin
        if (passed[k]) vphi_d = {vphi_d[N_PHASE-2:0], vphi_d[N_PHASE-1]};
      end
    end
  end
endmodule

// File: rtl/ccd_hclk_gen.sv
module ccd_hclk_gen #(
  parameter int unsigned PW        = 12,
  parameter int unsigned SW        = 1,
  parameter int unsigned BLANK_END = 260,
  parameter int unsigned OB_FRONT  = 2,
  parameter int unsigned PRESCAN   = 24,
  parameter int unsigned IMG_PIX   = 2096,
  parameter int unsigned OB_REAR   = 54,
  parameter int unsigned N_REGION  = 4
) (
  input  logic [SW-1:0]       sub,
  input  logic [PW-1:0]       pix,
  output logic                hd_d,
  output logic                h1_d,
  output logic                h2_d,
  output logic                rg_d,
  output logic [N_REGION-1:0] region_d
);
  import ccd_line_timing_pkg::*;

  localparam int unsigned FOB_LO = BLANK_END;
  localparam int unsigned PRE_LO = FOB_LO + OB_FRONT;
  localparam int unsigned IMG_LO = PRE_LO + PRESCAN;
  localparam int unsigned ROB_LO = IMG_LO + IMG_PIX;
  localparam int unsigned ROB_HI = ROB_LO + OB_REAR;

  logic first_half, frozen;

  always_comb begin
    first_half = (sub == '0);
    frozen     = (pix < PW'(BLANK_END));
    hd_d       = (pix == '0);
    rg_d       = first_half;
    h1_d       = !frozen && first_half;
    h2_d       = !h1_d;
    region_d   = '0;
    region_d[RG_FOB] = (pix >= PW'(FOB_LO)) && (pix < PW'(PRE_LO));
    region_d[RG_PRE] = (pix >= PW'(PRE_LO)) && (pix < PW'(IMG_LO));
    region_d[RG_IMG] = (pix >= PW'(IMG_LO)) && (pix < PW'(ROB_LO));
    region_d[RG_ROB] = (pix >= PW'(ROB_LO)) && (pix < PW'(ROB_HI));
  end
endmodule

// File: rtl/ccd_line_timing.sv
module ccd_line_timing
  import ccd_line_timing_pkg::*;
#(
  parameter int unsigned P_LINE_PIX   = LINE_PIX,
  parameter int unsigned P_SUB_TICKS  = SUB_TICKS,
  parameter int unsigned P_BLANK_END  = BLANK_END,
  parameter int unsigned P_EDGE_FIRST = EDGE_FIRST,
  parameter int unsigned P_EDGE_STEP  = EDGE_STEP,
  parameter int unsigned P_EDGE_MAX   = EDGE_MAX,
  parameter int unsigned P_N_PHASE    = N_PHASE,
  parameter int unsigned P_N_REGION   = N_REGION
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_mode,
  input  logic                  xfer_line,
  output logic                  hd,
  output logic                  h1,
  output logic                  h2,
  output logic                  rg,
  output logic [P_N_PHASE-1:0]  vphi,
  output logic [P_N_REGION-1:0] region
);
  localparam int unsigned PW = $clog2(P_LINE_PIX);
  localparam int unsigned SW = (P_SUB_TICKS > 1) ? $clog2(P_SUB_TICKS) : 1;
  localparam logic [P_N_PHASE-1:0] IDLE = P_N_PHASE'(2'b11);

  logic [SW-1:0]         sub_d;
  logic [PW-1:0]         pix_d;
  logic                  line_start;
  acc_mode_t             mode_q, mode_eff;
  logic                  xfer_q, xfer_eff;
  logic                  hd_d, h1_d, h2_d, rg_d;
  logic [P_N_PHASE-1:0]  vphi_d;
  logic [P_N_REGION-1:0] region_d;

  ccd_line_counter #(.LINE_PIX(P_LINE_PIX), .SUB_TICKS(P_SUB_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sub_d(sub_d), .pix_d(pix_d), .line_start(line_start)
  );

  always_comb begin
    mode_eff = line_start ? acc_mode_t'(frame_mode) : mode_q;
    xfer_eff = line_start ? xfer_line : xfer_q;
  end

  ccd_vphase_gen #(
    .PW(PW), .BLANK_END(P_BLANK_END), .EDGE_FIRST(P_EDGE_FIRST),
    .EDGE_STEP(P_EDGE_STEP), .EDGE_MAX(P_EDGE_MAX), .N_PHASE(P_N_PHASE)
  ) u_vph (
    .pix(pix_d), .frame_sel(mode_eff == MODE_FRAME), .xfer_en(xfer_eff), .vphi_d(vphi_d)
  );

  ccd_hclk_gen #(
    .PW(PW), .SW(SW), .BLANK_END(P_BLANK_END), .OB_FRONT(OB_FRONT),
    .PRESCAN(PRESCAN), .IMG_PIX(IMG_PIX), .OB_REAR(OB_REAR), .N_REGION(P_N_REGION)
  ) u_hclk (
    .sub(sub_d), .pix(pix_d), .hd_d(hd_d), .h1_d(h1_d), .h2_d(h2_d),
    .rg_d(rg_d), .region_d(region_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FIELD;
      xfer_q <= 1'b0;
    end else if (line_start) begin
      mode_q <= mode_eff;
      xfer_q <= xfer_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd     <= 1'b0;
      h1     <= 1'b0;
      h2     <= 1'b1;
      rg     <= 1'b0;
      vphi   <= IDLE;
      region <= '0;
    end else begin
      hd     <= hd_d;
      h1     <= h1_d;
      h2     <= h2_d;
      rg     <= rg_d;
      vphi   <= vphi_d;
      region <= region_d;
    end
  end
endmodule

// File: rtl/ccd_line_timing_chk.sv
module ccd_line_timing_chk #(
  parameter int unsigned NPH = 4,
  parameter int unsigned NRG = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hd,
  input logic           h1,
  input logic           h2,
  input logic           rg,
  input logic [NPH-1:0] vphi,
  input logic [NRG-1:0] region
);
  p_hd_two_clocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hd) |=> hd);
  p_hd_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hd && $past(hd)) |=> !hd);
  p_h_complement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h1 != h2);
  p_rg_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rg |=> !rg);
  p_vphi_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vphi) == 2);
  p_region_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region));
  p_region_on_h1_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(region) |-> $rose(h1));
  p_vstep_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vphi) |-> (!h1 && !$past(h1)));
endmodule

bind ccd_line_timing ccd_line_timing_chk #(.NPH(P_N_PHASE), .NRG(P_N_REGION)) u_chk (
  .clk(clk), .rst_n(rst_n), .hd(hd), .h1(h1), .h2(h2), .rg(rg),
  .vphi(vphi), .region(region)
);

// File: tb/ccd_line_timing_test.sv
module ccd_line_timing_test;
  localparam int CLK_PERIOD = 10;
  localparam int NLINES     = 9;

  logic clk = 1'b0;
  logic rst_n, frame_mode, xfer_line;
  logic hd, h1, h2, rg;
  logic [3:0] vphi, region;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_line_timing uut (
    .clk(clk), .rst_n(rst_n), .frame_mode(frame_mode), .xfer_line(xfer_line),
    .hd(hd), .h1(h1), .h2(h2), .rg(rg), .vphi(vphi), .region(region)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_vphi(input int pix, input bit frm, input bit xf);
    logic [3:0] p = 4'b0011;
    int sp = frm ? 56 : 28;
    if (xf && pix < 260)
      for (int i = 0; i < 8; i++)
        if (54 + i*sp < 260 && pix >= 54 + i*sp) p = {p[2:0], p[3]};
    return p;
  endfunction

  function automatic logic [3:0] exp_region(input int pix);
    if (pix >= 260 && pix <= 261)   return 4'b0001;
    if (pix >= 262 && pix <= 285)   return 4'b0010;
    if (pix >= 286 && pix <= 2381)  return 4'b0100;
    if (pix >= 2382 && pix <= 2435) return 4'b1000;
    return 4'b0000;
  endfunction

  int m_sub, m_pix, m_line;
  bit m_frm, m_xf;
  logic prev_h1;
  logic [3:0] prev_region;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; frame_mode = 1'b0; xfer_line = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 hd reset", {7'd0, hd}, 8'd0);
    check("R9 h1/h2 reset", {6'd0, h1, h2}, 8'b01);
    check("R9 rg reset", {7'd0, rg}, 8'd0);
    check("R9 vphi reset", {4'd0, vphi}, 8'h03);
    check("R9 region reset", {4'd0, region}, 8'h00);
    rst_n = 1'b1;
    m_sub = 1; m_pix = 2639; m_line = -1;
    prev_h1 = 1'b0; prev_region = 4'b0;
    for (int c = 0; c < NLINES * 5280; c++) begin
      @(posedge clk);
      m_sub = (m_sub + 1) % 2;
      if (m_sub == 0) m_pix = (m_pix + 1) % 2640;
      if (m_sub == 0 && m_pix == 0) begin
        m_frm = frame_mode; m_xf = xfer_line; m_line++;
      end
      @(negedge clk);
      check("R1 hd", {7'd0, hd}, {7'd0, m_pix == 0});
      if (m_pix < 260) check("R4 h1/h2 frozen", {6'd0, h1, h2}, 8'b01);
      else check("R3 h1/h2 toggle", {6'd0, h1, h2}, (m_sub == 0) ? 8'b10 : 8'b01);
      check("R5 rg", {7'd0, rg}, {7'd0, m_sub == 0});
      check(m_frm ? "R6 vphi frame" : "R6 vphi field", {4'd0, vphi},
            {4'd0, exp_vphi(m_pix, m_frm, m_xf)});
      check("R7 region", {4'd0, region}, {4'd0, exp_region(m_pix)});
      if (region !== prev_region) check("R8 region on h1 rise", {6'd0, prev_h1, h1}, 8'b01);
      prev_h1 = h1; prev_region = region;
      if (m_sub == 0 && m_pix == 100) begin
        frame_mode = ~frame_mode;   // R2: mid-line change must not matter
        xfer_line  = ~xfer_line;
      end
      if (m_sub == 0 && m_pix == 1500) begin
        case (m_line)
          0: begin frame_mode = 1'b1; xfer_line = 1'b1; end
          1: begin frame_mode = 1'b0; xfer_line = 1'b0; end
          2: begin frame_mode = 1'b1; xfer_line = 1'b0; end
          default: begin
            frame_mode = 1'($urandom);
            xfer_line  = 1'($urandom);
          end
        endcase
      end
      if (m_sub == 1 && m_pix == 2639 && ($urandom % 2) == 1) begin
        frame_mode = ~frame_mode;   // R2: last-half change is captured at the next edge
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule